// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host side of a link to a 12-bit converter with a serial output. It divides the system clock down to a serial clock. It drives an active-low chip select and a shutdown line, and it shifts in the converter's data line. Each 16-bit frame carries a 4-bit header that must be zero, followed by a 12-bit result. When the header is clean, the result appears on a parallel bus with a one-cycle valid pulse. When the header is not zero, an error pulse is raised instead.

A conversion starts from the `start` input, and `cont_mode` is captured at that moment. In slave mode, every conversion gets its own falling edge on chip select, and chip select is released after 16 clocks. In continuous mode, chip select stays low and the serial clock runs without a break. The converter's status line then marks where each frame begins and ends, and one dead clock separates frames. A power-down request raises shutdown at once and drops any frame in progress. Before the next conversion, the block enforces the converter's wake-up time, and it also keeps the setup gap between chip select and the first clock.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, `adc_cs_n`=1, `adc_sclk`=0, `adc_shdn`=0, `res_valid`=0, `frame_err`=0 and `ready`=0.
- R2: After reset is released, or after `adc_shdn` falls, at least WAKE_CYC = ceil(WAKE_US·CLK_HZ/1e6) cycles pass before `ready` rises or `adc_cs_n` falls.
- R3: From a fall of `adc_cs_n` to the next rise of `adc_sclk`, at least SETUP_CYC = ceil(SETUP_NS·CLK_HZ/1e9) cycles pass.
- R4: `adc_sclk` has a period of 2·HALF cycles, where HALF = ceil(CLK_HZ/(2·SCLK_HZ)). It is low in every cycle that follows a cycle with `adc_cs_n` high.
- R5: In slave mode, chip select stays low for exactly 16 rising serial clock edges. It then goes high, and it does not fall again until a new `start`.
- R6: `adc_dout` is sampled at each rising serial clock edge. The first bit is frame bit 15, bits 15..12 form the header and bits 11..0 form the result. With a zero header, `res_valid` is high for one cycle and `res_code` equals bits 11..0. This happens 2 cycles after the cycle in which `adc_sclk` goes high for the 16th bit.
- R7: If the header is not zero, `frame_err` pulses in the cycle where `res_valid` would have pulsed, and `res_valid` stays low.
- R8: In continuous mode, `adc_cs_n` stays low until a power-down request. A bit is accepted only while `adc_status`=1, and only after a rising edge has been seen with `adc_status`=0. A partial frame at startup is therefore discarded. With one dead clock, results come every 17 serial clocks.
- R9: A `pdown_req` drives `adc_shdn`=1 and `adc_cs_n`=1 in the next cycle and `adc_sclk`=0 one cycle later, and the partial frame produces no output.
- R10: `start` is ignored while `ready`=0, and `cont_mode` only has effect when it is sampled with an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (accepted when ready) |
| cont_mode | input | 1 | 1 = continuous, 0 = slave; sampled on start |
| pdown_req | input | 1 | Power-down request (level) |
| adc_dout | input | 1 | Converter serial data |
| adc_status | input | 1 | Converter status, high during a frame |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_shdn | output | 1 | Converter shutdown, high = powered down |
| res_code | output | CODE_W | Last good result |
| res_valid | output | 1 | One-cycle strobe for a good result |
| frame_err | output | 1 | One-cycle strobe for a nonzero header |
| ready | output | 1 | Idle and awake; start is accepted |

## Verification
A result is due exactly 2 system cycles after the cycle in which the serial clock goes high for a frame's 16th bit. One cycle covers the shift register and one covers the result register. The bench's converter model records that cycle in a queue of expected results, together with the header verdict. On every clock, the bench compares `res_valid` and `frame_err` against the head of that queue, so an output that comes early, late, duplicated or missing is a miscompare. The setup and wake-up gaps are measured as minimum cycle counts between edges. Serial clock periods are checked exactly, and the outputs after a power-down are checked 2 cycles after the request.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    function automatic longint unsigned ceil_div(longint unsigned n, longint unsigned d);
        return (n + d - 1) / d;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAKE,
        ST_IDLE,
        ST_SETUP,
        ST_RUN,
        ST_GAP
    } rd_state_e;

endpackage

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
    parameter int HALF = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk,
    output logic rise
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            sclk <= 1'b0;
            rise <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (cnt == CW'(HALF - 1)) begin
                cnt  <= '0;
                sclk <= ~sclk;
                rise <= ~sclk;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4
    rise_marks_high_chk: assert property (@(posedge clk) disable iff (rst) rise |-> sclk);
    // R4
    rise_seen_chk: assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> rise);

endmodule

// File: rtl/adc_rd_frame.sv
module adc_rd_frame #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          use_status,
    input  logic          rise,
    input  logic          din,
    input  logic          status,
    output logic          done,
    output logic [FW-1:0] word
);
    localparam int NW = $clog2(FW + 1);

    logic [NW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt   <= '0;
            armed <= !use_status;
            done  <= 1'b0;
            if (rst) word <= '0;
        end else begin
            done <= 1'b0;
            if (rise) begin
                if (use_status && !status) begin
                    armed <= 1'b1;
                    cnt   <= '0;
                end else if (armed) begin
                    word <= {word[FW-2:0], din};
                    if (cnt == NW'(FW - 1)) begin
                        done  <= 1'b1;
                        cnt   <= '0;
                        armed <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R5
    bit_count_range_chk: assert property (@(posedge clk) disable iff (rst) cnt < NW'(FW));
    // R6
    done_follows_rise_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(rise));
    // R8
    status_low_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && use_status && !status && !flush) |=> !done);

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adc_rd_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int SCLK_HZ  = 4_000_000,
    parameter int SETUP_NS = 90,
    parameter int WAKE_US  = 20,
    parameter int CODE_W   = 12,
    parameter int HDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cont_mode,
    input  logic              pdown_req,
    input  logic              adc_dout,
    input  logic              adc_status,
    output logic              adc_sclk,
    output logic              adc_cs_n,
    output logic              adc_shdn,
    output logic [CODE_W-1:0] res_code,
    output logic              res_valid,
    output logic              frame_err,
    output logic              ready
);
    localparam int FW        = HDR_W + CODE_W;
    localparam int HALF      = int'(ceil_div(64'(CLK_HZ), 64'(2) * 64'(SCLK_HZ)));
    localparam int SETUP_CYC = int'(ceil_div(64'(SETUP_NS) * 64'(CLK_HZ), 64'd1_000_000_000));
    localparam int WAKE_CYC  = int'(ceil_div(64'(WAKE_US) * 64'(CLK_HZ), 64'd1_000_000));
    localparam int GAP_CYC   = HALF;
    localparam int TMAX      = max3(WAKE_CYC, SETUP_CYC, GAP_CYC);
    localparam int TW        = $clog2(TMAX + 1);

    typedef struct packed {
        logic [HDR_W-1:0]  hdr;
        logic [CODE_W-1:0] code;
    } frame_t;

    rd_state_e     state;
    logic [TW-1:0] tcnt;
    logic          cont_q;
    logic          sclk_rise;
    logic          frm_done;
    logic [FW-1:0] frm_word;
    frame_t        frm;

    assign frm      = frame_t'(frm_word);
    assign adc_cs_n = !(state == ST_SETUP || state == ST_RUN);
    assign adc_shdn = (state == ST_OFF);
    assign ready    = (state == ST_IDLE);

    adc_rd_sclk #(.HALF(HALF)) u_sclk (
        .clk  (clk),
        .rst  (rst),
        .en   (state == ST_RUN),
        .sclk (adc_sclk),
        .rise (sclk_rise)
    );

    adc_rd_frame #(.FW(FW)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .flush      (state != ST_RUN),
        .use_status (cont_q),
        .rise       (sclk_rise),
        .din        (adc_dout),
        .status     (adc_status),
        .done       (frm_done),
        .word       (frm_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_WAKE;
            tcnt   <= '0;
            cont_q <= 1'b0;
        end else if (pdown_req) begin
            state <= ST_OFF;
            tcnt  <= '0;
        end else begin
            case (state)
                ST_OFF: begin
                    state <= ST_WAKE;
                    tcnt  <= '0;
                end
                ST_WAKE: begin
                    if (tcnt == TW'(WAKE_CYC - 1)) begin
                        state <= ST_IDLE;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (start) begin
                        cont_q <= cont_mode;
                        state  <= ST_SETUP;
                        tcnt   <= '0;
                    end
                end
                ST_SETUP: begin
                    if (tcnt == TW'(SETUP_CYC - 1)) begin
                        state <= ST_RUN;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (frm_done && !cont_q) begin
                        state <= ST_GAP;
                        tcnt  <= '0;
                    end
                end
                ST_GAP: begin
                    if (tcnt == TW'(GAP_CYC - 1)) begin
                        state <= ST_IDLE;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            frame_err <= 1'b0;
            res_code  <= '0;
        end else begin
            res_valid <= 1'b0;
            frame_err <= 1'b0;
            if (frm_done) begin
                if (frm.hdr == '0) begin
                    res_valid <= 1'b1;
                    res_code  <= frm.code;
                end else begin
                    frame_err <= 1'b1;
                end
            end
        end
    end

    // R2
    wake_span_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state == ST_WAKE)) |-> ($past(tcnt) == TW'(WAKE_CYC - 1)));
    // R4
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (rst) adc_cs_n |=> !adc_sclk);
    // R6
    valid_after_done_chk: assert property (@(posedge clk) disable iff (rst) res_valid |-> $past(frm_done));
    // R7
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst) !(res_valid && frame_err));
    // R9
    shdn_deselect_chk: assert property (@(posedge clk) disable iff (rst) adc_shdn |-> adc_cs_n);
    // R9
    pdown_reacts_chk: assert property (@(posedge clk) disable iff (rst) pdown_req |=> adc_shdn);

endmodule

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;
    localparam int CLK_HZ    = 100_000_000;
    localparam int SCLK_HZ   = 4_000_000;
    localparam int HALF      = (CLK_HZ + 2 * SCLK_HZ - 1) / (2 * SCLK_HZ);
    localparam int SETUP_CYC = int'((64'(90) * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000);
    localparam int WAKE_CYC  = int'((64'(20) * CLK_HZ + 64'd999_999) / 64'd1_000_000);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, cont_mode = 1'b0, pdown_req = 1'b0;
    logic        adc_dout = 1'b0, adc_status = 1'b0;
    logic        adc_sclk, adc_cs_n, adc_shdn, res_valid, frame_err, ready;
    logic [11:0] res_code;

    adc_serial_reader u_adc_serial_reader (
        .clk(clk), .rst(rst), .start(start), .cont_mode(cont_mode), .pdown_req(pdown_req),
        .adc_dout(adc_dout), .adc_status(adc_status), .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n),
        .adc_shdn(adc_shdn), .res_code(res_code), .res_valid(res_valid), .frame_err(frame_err),
        .ready(ready)
    );

    always #5 clk = ~clk;

    int vectors = 0, errors = 0, cyc = 0, seen = 0;
    bit bench_cont = 0, pd_abort = 0, run_on = 0, done_flag = 0;

    logic [15:0] send_q[$];
    int          due_q[$];
    logic [15:0] expw_q[$];

    logic [15:0] word;
    int bitidx, pos, rises, cs_fall_cyc, shdn_rel_cyc, last_rise;
    bit prev_sclk = 0, prev_cs = 1, prev_shdn = 0, armed = 0, full = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] next_word();
        if (send_q.size() > 0) return send_q.pop_front();
        return 16'h0DEF;
    endfunction

    task automatic push_exp(logic [15:0] w);
        due_q.push_back(cyc + 2);
        expw_q.push_back(w);
    endtask

    always @(negedge clk) begin
        bit cs_fall, cs_rise, s_fall, s_rise;
        cyc++;
        if (cyc > 100000 && !done_flag) begin
            chk(0, "WD", "watchdog expired", cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
        if (run_on) begin
            cs_fall = prev_cs && !adc_cs_n;
            cs_rise = !prev_cs && adc_cs_n;
            s_fall  = prev_sclk && !adc_sclk;
            s_rise  = !prev_sclk && adc_sclk;
            if (prev_shdn && !adc_shdn) shdn_rel_cyc = cyc;
            // R9: shutdown implies deselected
            if (adc_shdn) chk(adc_cs_n, "R9", "cs_n while shdn", adc_cs_n, 1);
            // R4: clock quiet after a deselected cycle
            if (prev_cs) chk(!adc_sclk, "R4", "sclk after cs_n high", adc_sclk, 0);
            if (cs_fall) begin
                // R2: wake-up gap
                chk(cyc - shdn_rel_cyc >= WAKE_CYC, "R2", "wake gap", cyc - shdn_rel_cyc, WAKE_CYC);
                cs_fall_cyc = cyc; rises = 0; last_rise = -1; armed = 0; full = 0;
                if (!bench_cont) begin
                    word = next_word(); bitidx = 15;
                    adc_dout = word[15]; adc_status = 1'b1;
                end else begin
                    word = 16'h0DEF; pos = 5;
                    adc_status = 1'b1; adc_dout = word[15-pos];
                end
            end else if (s_fall && !adc_cs_n) begin
                if (!bench_cont) begin
                    bitidx--;
                    adc_dout = (bitidx >= 0) ? word[bitidx] : 1'b0;
                end else begin
                    pos = (pos == 16) ? 0 : pos + 1;
                    if (pos == 0) word = next_word();
                    adc_status = (pos < 16);
                    adc_dout = (pos < 16) ? word[15-pos] : 1'b0;
                end
            end
            if (s_rise && !adc_cs_n) begin
                rises++;
                // R3: setup gap before first rise
                if (rises == 1)
                    chk(cyc - cs_fall_cyc >= SETUP_CYC, "R3", "cs to sclk", cyc - cs_fall_cyc, SETUP_CYC);
                // R4: period
                if (last_rise >= 0)
                    chk(cyc - last_rise == 2 * HALF, "R4", "sclk period", cyc - last_rise, 2 * HALF);
                last_rise = cyc;
                if (!bench_cont) begin
                    if (rises == 16) push_exp(word);
                end else begin
                    if (pos == 16) begin armed = 1; full = 0; end
                    else if (armed) begin
                        if (pos == 0) full = 1;
                        if (pos == 15 && full) push_exp(word);
                    end
                end
            end
            if (cs_rise && !pdown_req && !pd_abort) begin
                // R5 / R8
                if (!bench_cont) chk(rises == 16, "R5", "rises per select", rises, 16);
                else chk(0, "R8", "cs_n rose in continuous mode", 1, 0);
            end
            // R6 / R7: output compared every cycle
            if (res_valid || frame_err) begin
                if (due_q.size() == 0) chk(0, "R6", "unexpected output", cyc, -1);
                else begin
                    int d; logic [15:0] w;
                    d = due_q.pop_front(); w = expw_q.pop_front();
                    seen++;
                    chk(d == cyc, "R6", "result timing", cyc, d);
                    if (w[15:12] != 4'h0)
                        chk(frame_err && !res_valid, "R7", "header error strobe", {frame_err, res_valid}, 2);
                    else begin
                        chk(res_valid && !frame_err, "R6", "valid strobe", {frame_err, res_valid}, 1);
                        chk(res_code == w[11:0], "R6", "result code", res_code, w[11:0]);
                    end
                end
            end else begin
                vectors++;
                if (due_q.size() > 0 && due_q[0] < cyc) begin
                    chk(0, "R6", "missing result", -1, expw_q[0]);
                    void'(due_q.pop_front()); void'(expw_q.pop_front());
                end
            end
            prev_cs = adc_cs_n; prev_sclk = adc_sclk; prev_shdn = adc_shdn;
        end
    end

    task automatic wait_ready(string req);
        int n = 0;
        while (!ready && n < 20000) begin @(negedge clk); n++; end
        chk(ready, req, "ready reached", ready, 1);
    endtask

    task automatic slave_frame(logic [15:0] w, bit poke);
        send_q.push_back(w);
        bench_cont = 0; pd_abort = 0;
        cont_mode = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            // R10: start and mode changes while busy have no effect
            cont_mode = 1'b1; start = 1'b1;
            @(negedge clk); start = 1'b0; cont_mode = 1'b0;
        end
        wait_ready("R5");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        shdn_rel_cyc = cyc + 1;
        run_on = 1;
        @(negedge clk);
        // R1: reset state
        chk(adc_cs_n == 1 && adc_sclk == 0 && adc_shdn == 0, "R1", "pins after reset",
            {adc_cs_n, adc_sclk, adc_shdn}, 3'b100);
        chk(!res_valid && !frame_err && !ready, "R1", "strobes after reset",
            {res_valid, frame_err, ready}, 0);
        repeat (WAKE_CYC - 10) @(negedge clk);
        chk(!ready, "R2", "ready before wake gap", ready, 0);
        wait_ready("R2");

        slave_frame(16'h0000, 0);
        slave_frame(16'h0FFF, 1);
        slave_frame(16'h0A5A, 0);
        slave_frame(16'h9123, 0);   // R7: bad header
        slave_frame(16'h05C3, 0);
        repeat (200) @(negedge clk);
        // R10: no new select without start
        chk(adc_cs_n && ready, "R10", "idle without start", {adc_cs_n, ready}, 3);
        chk(seen == 5, "R6", "slave results seen", seen, 5);

        // R9: power-down mid-frame
        send_q.push_back(16'h0777);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (9 + 13 + 8 * 26) @(negedge clk);
        pdown_req = 1'b1; pd_abort = 1;
        @(negedge clk);
        @(negedge clk);
        chk(adc_shdn && adc_cs_n && !adc_sclk, "R9", "pins after pdown",
            {adc_shdn, adc_cs_n, adc_sclk}, 3'b110);
        repeat (60) @(negedge clk);
        chk(seen == 5, "R9", "no output from aborted frame", seen, 5);
        pdown_req = 1'b0;
        wait_ready("R2");
        pd_abort = 0;

        // R8: continuous mode
        send_q.push_back(16'h0123);
        send_q.push_back(16'h0F0F);
        send_q.push_back(16'h1456);
        send_q.push_back(16'h0ABC);
        bench_cont = 1; cont_mode = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0; cont_mode = 1'b0;
        begin
            int n = 0;
            while (seen < 9 && n < 20000) begin @(negedge clk); n++; end
        end
        chk(seen == 9, "R8", "continuous results seen", seen, 9);
        repeat (100) @(negedge clk);
        pd_abort = 1; pdown_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(adc_shdn && adc_cs_n, "R9", "pdown ends continuous", {adc_shdn, adc_cs_n}, 3);
        pdown_req = 1'b0;
        repeat (50) @(negedge clk);
        chk(due_q.size() == 0, "R6", "no results outstanding", due_q.size(), 0);
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule